// File: doc/BRIEF.md
# Dual-Slot Ethernet Receive Buffer Controller

This block takes received Ethernet frames as a byte stream with a valid/ready handshake and places each frame into one of two on-chip receive slots. Software owns the slots through a small ownership handshake. It marks a slot as loaded to hand it to the block. The block fills the slot with a complete frame image and then marks it pending, which hands the slot back to software.

The image in the slot is rebuilt by the block. It holds the preamble and start delimiter, the payload, zero padding up to the minimum payload length, and a computed frame check sequence. The stored byte count goes into the slot's count output. A level interrupt stays high while any slot is pending. A separate availability output tells the upstream source whether a slot is free to take a frame. Software reads the stored image through a registered read port.

Top module: `rx_dual_slot_buf`

## Requirements
- R1: Slot states are encoded as empty = 0, loaded = 1 and pending = 2. After reset both states are empty, both counts are 0, and `rx_irq` and `slot_avail` are low.
- R2: A frame whose first byte is accepted while slot 0 is loaded goes to slot 0. Otherwise it goes to slot 1 if slot 1 is loaded. A slot becomes pending only from the loaded state.
- R3: A frame that starts while neither slot is loaded is consumed up to its last byte and discarded. Both slot states and both counts stay unchanged.
- R4: In the stored image, bytes 0 to 6 are 0x55 and byte 7 is 0xD5. The payload bytes follow in arrival order, starting at byte 8.
- R5: A payload shorter than 60 bytes is extended with zero bytes to 60 bytes. A payload of 60 bytes or more is not extended.
- R6: The four bytes that follow the padded payload hold the CRC-32 of the padded payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an all-ones start value and a final inversion. The preamble and delimiter are not covered.
- R7: When a frame is complete, the slot's count becomes the padded payload length plus 12, and its state becomes pending. No count smaller than 72 is ever recorded.
- R8: `rx_irq` is high exactly when at least one slot is pending. It follows both software state writes and frame completion.
- R9: `slot_avail` is high exactly when at least one slot is loaded.
- R10: A byte accepted with `in_err` high aborts the frame. The rest of the frame is discarded, and the slot state and count stay unchanged.
- R11: A payload longer than 2036 bytes (slot size 2048 minus 12) aborts the frame and leaves the slot unchanged. A payload of exactly 2036 bytes is stored, with a count of 2048.
- R12: A pulse on `ctl_we` sets the state of slot `ctl_slot` to `ctl_state` on the next cycle. If frame completion targets the same slot in the same cycle, completion takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream payload byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Marks the frame as bad, which aborts it |
| in_ready | output | 1 | Block accepts a stream byte this cycle |
| slot_avail | output | 1 | At least one slot is loaded |
| ctl_we | input | 1 | Software state write strobe |
| ctl_slot | input | 1 | Slot targeted by the state write |
| ctl_state | input | 2 | State value to write |
| state0 | output | 2 | Slot 0 state |
| state1 | output | 2 | Slot 1 state |
| count0 | output | 12 | Slot 0 stored byte count |
| count1 | output | 12 | Slot 1 stored byte count |
| rx_irq | output | 1 | Level interrupt, high while any slot is pending |
| rd_slot | input | 1 | Buffer read slot select |
| rd_addr | input | 11 | Buffer read byte offset |
| rd_data | output | 8 | Buffer read data, one cycle after the address |

## Verification
The checks assume that software writes only the values 0, 1 and 2 to a slot state. They also assume that software does not reload a slot while a frame is being stored into it. The assertion that a slot becomes pending only from loaded depends on both of these. The stimulus keeps to these rules: it changes slot states only while the stream is idle and the scoreboard has drained, and it never writes the unused code 3. Stream bytes are driven only through the valid/ready handshake.

// File: rtl/rxb_pkg.sv
// Shared types and constants for the dual-slot receive buffer.
// Assumes byte-wide stream data and a standard reflected CRC-32.
package rxb_pkg;

    localparam int NUM_SLOTS      = 2;
    localparam int MIN_PAYLOAD    = 60;
    localparam int FRAME_OVERHEAD = 12;
    localparam int PREAMBLE_LEN   = 8;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_LOADED  = 2'd1,
        SLOT_PENDING = 2'd2
    } slot_st_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PAY,
        PH_DROP,
        PH_PAD,
        PH_FCS,
        PH_PRE,
        PH_DONE
    } phase_t;

    // Advance a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxb_crc32.sv
// Running CRC-32 accumulator.
// Assumes: clr takes priority over en; fcs is the inverted register, ready to store.
module rxb_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    import rxb_pkg::*;

    logic [31:0] crc_q;

    // Accumulate one byte per enabled cycle, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/rxb_bufram.sv
// Two-slot byte buffer with one write port and one registered read port.
// Assumes: each slot spans SLOT_BYTES bytes, SLOT_BYTES a power of two.
module rxb_bufram #(
    parameter int SLOT_BYTES = 2048,
    localparam int AW = $clog2(SLOT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wslot,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rslot,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 2 * SLOT_BYTES;

    logic [7:0] mem [DEPTH];

    // Store one byte when the capture engine writes.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wslot, waddr}] <= wdata;
        end
    end

    // Registered read for the software side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[{rslot, raddr}];
        end
    end
endmodule

// File: rtl/rxb_slot_regs.sv
// Per-slot ownership state, stored count, and the derived interrupt and availability flags.
// Assumes: a frame commit overrides a software write to the same slot in the same cycle.
module rxb_slot_regs #(
    parameter int CNT_W = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     sw_we,
    input  logic                                     sw_slot,
    input  logic [1:0]                               sw_val,
    input  logic                                     cm_en,
    input  logic                                     cm_slot,
    input  logic [CNT_W-1:0]                         cm_count,
    output logic [rxb_pkg::NUM_SLOTS-1:0][1:0]       state_o,
    output logic [rxb_pkg::NUM_SLOTS-1:0][CNT_W-1:0] count_o,
    output logic                                     irq_o,
    output logic                                     avail_o
);
    import rxb_pkg::*;

    logic [NUM_SLOTS-1:0] pend_nxt;
    logic [NUM_SLOTS-1:0] load_nxt;

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        localparam logic SEL = (gi != 0);
        logic [1:0]       st_q;
        logic [1:0]       st_d;
        logic [CNT_W-1:0] cnt_q;
        logic             hit_cm;

        assign hit_cm = cm_en && (cm_slot == SEL);

        // Next state: commit first, then software write.
        always_comb begin
            st_d = st_q;
            if (hit_cm) begin
                st_d = SLOT_PENDING;
            end else if (sw_we && (sw_slot == SEL)) begin
                st_d = sw_val;
            end
        end

        // Hold state and count for this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= SLOT_EMPTY;
                cnt_q <= '0;
            end else begin
                st_q <= st_d;
                if (hit_cm) begin
                    cnt_q <= cm_count;
                end
            end
        end

        assign pend_nxt[gi] = (st_d == SLOT_PENDING);
        assign load_nxt[gi] = (st_d == SLOT_LOADED);
        assign state_o[gi]  = st_q;
        assign count_o[gi]  = cnt_q;
    end

    // Register the flags from next state so they track the state outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o   <= 1'b0;
            avail_o <= 1'b0;
        end else begin
            irq_o   <= |pend_nxt;
            avail_o <= |load_nxt;
        end
    end
endmodule

// File: rtl/rxb_capture.sv
// Frame capture sequencer. It stores payload bytes from offset 8 while they arrive, then
// pads to the minimum length, appends the FCS, writes the preamble last, and commits.
// Assumes: slot choice is made at the first byte and held for the frame; the stream
// is stalled (in_ready low) only during the tail.
module rxb_capture #(
    parameter int SLOT_BYTES = 2048,
    localparam int AW    = $clog2(SLOT_BYTES),
    localparam int CNT_W = $clog2(SLOT_BYTES + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [7:0]                         in_data,
    input  logic                               in_last,
    input  logic                               in_err,
    output logic                               in_ready,
    input  logic [rxb_pkg::NUM_SLOTS-1:0][1:0] slot_state,
    input  logic [31:0]                        fcs,
    output logic                               crc_clr,
    output logic                               crc_en,
    output logic [7:0]                         crc_din,
    output logic                               wr_en,
    output logic                               wr_slot,
    output logic [AW-1:0]                      wr_addr,
    output logic [7:0]                         wr_data,
    output logic                               cm_en,
    output logic                               cm_slot,
    output logic [CNT_W-1:0]                   cm_count
);
    import rxb_pkg::*;

    localparam logic [AW-1:0] MAX_PAY   = AW'(SLOT_BYTES - FRAME_OVERHEAD);
    localparam logic [AW-1:0] PRE_A     = AW'(PREAMBLE_LEN);
    localparam logic [AW:0]   MIN_PAY_L = (AW + 1)'(MIN_PAYLOAD);

    phase_t        phase_q;
    logic          sel_q;
    logic [AW-1:0] len_q;
    logic [2:0]    idx_q;

    logic          accept;
    logic          tgt_ok;
    logic          tgt;
    logic          cur_slot;
    logic          storing;
    logic          bad;
    logic          good_byte;
    logic [AW:0]   len_inc;

    assign in_ready  = (phase_q == PH_IDLE) || (phase_q == PH_PAY) || (phase_q == PH_DROP);
    assign accept    = in_valid && in_ready;
    assign tgt_ok    = (slot_state[0] == SLOT_LOADED) || (slot_state[1] == SLOT_LOADED);
    assign tgt       = (slot_state[0] == SLOT_LOADED) ? 1'b0 : 1'b1;
    assign cur_slot  = (phase_q == PH_IDLE) ? tgt : sel_q;
    assign storing   = accept && (((phase_q == PH_IDLE) && tgt_ok) || (phase_q == PH_PAY));
    assign bad       = in_err || (len_q == MAX_PAY);
    assign good_byte = storing && !bad;
    assign len_inc   = {1'b0, len_q} + (AW + 1)'(1);

    assign crc_clr  = ((phase_q == PH_IDLE) && !good_byte) || (phase_q == PH_DROP)
                    || (phase_q == PH_DONE) || (storing && bad);
    assign wr_slot  = cur_slot;
    assign cm_slot  = sel_q;
    assign cm_count = CNT_W'(len_q) + CNT_W'(FRAME_OVERHEAD);

    // Drive the buffer write, the CRC feed and the commit strobe for the current phase.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        crc_en  = 1'b0;
        crc_din = '0;
        cm_en   = 1'b0;
        case (phase_q)
            PH_PAD: begin
                wr_en   = 1'b1;
                wr_addr = PRE_A + len_q;
                crc_en  = 1'b1;
            end
            PH_FCS: begin
                wr_en   = 1'b1;
                wr_addr = PRE_A + len_q + AW'(idx_q);
                wr_data = 8'(fcs >> {idx_q[1:0], 3'b000});
            end
            PH_PRE: begin
                wr_en   = 1'b1;
                wr_addr = AW'(idx_q);
                wr_data = (idx_q == 3'd7) ? SFD_BYTE : PRE_BYTE;
            end
            PH_DONE: begin
                cm_en = 1'b1;
            end
            default: begin
                if (good_byte) begin
                    wr_en   = 1'b1;
                    wr_addr = PRE_A + len_q;
                    wr_data = in_data;
                    crc_en  = 1'b1;
                    crc_din = in_data;
                end
            end
        endcase
    end

    // Sequence the phases and track the payload length and tail index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sel_q   <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_PAY: begin
                    if (accept) begin
                        if (!storing || bad) begin
                            phase_q <= in_last ? PH_IDLE : PH_DROP;
                            len_q   <= '0;
                        end else begin
                            sel_q <= cur_slot;
                            len_q <= len_q + AW'(1);
                            if (in_last) begin
                                phase_q <= (len_inc < MIN_PAY_L) ? PH_PAD : PH_FCS;
                            end else begin
                                phase_q <= PH_PAY;
                            end
                        end
                    end
                end
                PH_DROP: begin
                    if (accept && in_last) begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_PAD: begin
                    len_q <= len_q + AW'(1);
                    if (len_inc == MIN_PAY_L) begin
                        phase_q <= PH_FCS;
                    end
                end
                PH_FCS: begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == 3'd3) begin
                        idx_q   <= '0;
                        phase_q <= PH_PRE;
                    end
                end
                PH_PRE: begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == 3'd7) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_DONE: begin
                    phase_q <= PH_IDLE;
                    len_q   <= '0;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_dual_slot_buf.sv
// Top level of the dual-slot receive buffer: capture sequencer, CRC, slot registers, buffer.
// Assumes: software changes a slot state only when that slot is not being filled.
module rx_dual_slot_buf #(
    parameter int SLOT_BYTES = 2048,
    localparam int AW    = $clog2(SLOT_BYTES),
    localparam int CNT_W = $clog2(SLOT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_err,
    output logic             in_ready,
    output logic             slot_avail,
    input  logic             ctl_we,
    input  logic             ctl_slot,
    input  logic [1:0]       ctl_state,
    output logic [1:0]       state0,
    output logic [1:0]       state1,
    output logic [CNT_W-1:0] count0,
    output logic [CNT_W-1:0] count1,
    output logic             rx_irq,
    input  logic             rd_slot,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    import rxb_pkg::*;

    logic [NUM_SLOTS-1:0][1:0]       st_w;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_w;
    logic [31:0]      fcs;
    logic             crc_clr;
    logic             crc_en;
    logic [7:0]       crc_din;
    logic             wr_en;
    logic             wr_slot;
    logic [AW-1:0]    wr_addr;
    logic [7:0]       wr_data;
    logic             cm_en;
    logic             cm_slot;
    logic [CNT_W-1:0] cm_count;

    rxb_capture #(.SLOT_BYTES(SLOT_BYTES)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .slot_state(st_w), .fcs(fcs),
        .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
        .cm_en(cm_en), .cm_slot(cm_slot), .cm_count(cm_count)
    );

    rxb_crc32 crc_i (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .fcs(fcs)
    );

    rxb_slot_regs #(.CNT_W(CNT_W)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .sw_we(ctl_we), .sw_slot(ctl_slot), .sw_val(ctl_state),
        .cm_en(cm_en), .cm_slot(cm_slot), .cm_count(cm_count),
        .state_o(st_w), .count_o(cnt_w), .irq_o(rx_irq), .avail_o(slot_avail)
    );

    rxb_bufram #(.SLOT_BYTES(SLOT_BYTES)) ram_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wslot(wr_slot), .waddr(wr_addr), .wdata(wr_data),
        .rslot(rd_slot), .raddr(rd_addr), .rdata(rd_data)
    );

    assign state0 = st_w[0];
    assign state1 = st_w[1];
    assign count0 = cnt_w[0];
    assign count1 = cnt_w[1];
endmodule

// File: rtl/rxb_checker.sv
// Property checker bound to the receive buffer top.
// Assumes: software writes only codes 0..2 to slot states.
module rxb_checker #(
    parameter int SLOT_BYTES = 2048,
    localparam int CNT_W = $clog2(SLOT_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             ctl_slot,
    input logic [1:0]       ctl_state,
    input logic [1:0]       state0,
    input logic [1:0]       state1,
    input logic [CNT_W-1:0] count0,
    input logic             rx_irq,
    input logic             slot_avail,
    input logic             cm_en
);
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == ((state0 == 2'd2) || (state1 == 2'd2))); // R8

    AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        slot_avail == ((state0 == 2'd1) || (state1 == 2'd1))); // R9

    AST_PEND0_FROM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (state0 == 2'd2 && $past(state0) != 2'd2 && !$past(ctl_we)) |-> $past(state0) == 2'd1); // R2

    AST_PEND1_FROM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (state1 == 2'd2 && $past(state1) != 2'd2 && !$past(ctl_we)) |-> $past(state1) == 2'd1); // R2

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state0 == 2'd2 && $past(state0) != 2'd2 && !$past(ctl_we))
        |-> (count0 >= CNT_W'(72) && count0 <= CNT_W'(SLOT_BYTES))); // R7

    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_slot && !cm_en) |=> state0 == $past(ctl_state)); // R12
endmodule

bind rx_dual_slot_buf rxb_checker #(.SLOT_BYTES(SLOT_BYTES)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_slot(ctl_slot), .ctl_state(ctl_state),
    .state0(state0), .state1(state1), .count0(count0), .rx_irq(rx_irq),
    .slot_avail(slot_avail), .cm_en(cm_en)
);

// File: tb/rx_dual_slot_buf_tb_top.sv
// Scoreboard bench: the driver queues expected slot images, the monitor compares them.
module rx_dual_slot_buf_tb_top;
    localparam int SLOT_BYTES = 2048;
    localparam int AW = 11;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, slot_avail, rx_irq;
    logic ctl_we = 1'b0, ctl_slot = 1'b0;
    logic [1:0] ctl_state = '0;
    logic [1:0] state0, state1;
    logic [CW-1:0] count0, count1;
    logic rd_slot = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    bit mon_busy = 0;

    logic [7:0] exp_img[$];
    int exp_slot[$];
    int exp_plen[$];
    int m_st[2];
    int m_cnt[2];

    always #4 clk = ~clk;

    rx_dual_slot_buf dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_err(in_err), .in_ready(in_ready), .slot_avail(slot_avail), .ctl_we(ctl_we),
        .ctl_slot(ctl_slot), .ctl_state(ctl_state), .state0(state0), .state1(state1),
        .count0(count0), .count1(count1), .rx_irq(rx_irq), .rd_slot(rd_slot),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fcs(input logic [7:0] d[$]);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        foreach (d[i]) begin
            c = c ^ {24'd0, d[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] pay_byte(input int seed, input int i);
        return 8'((seed * 13 + i * 7 + (i >> 3)) & 255);
    endfunction

    // Compare model slot registers at the ports after a frame that must leave them alone.
    task automatic check_slots_kept(input string req);
        check(state0 == 2'(m_st[0]), req, "state0 unchanged", state0, m_st[0]);
        check(state1 == 2'(m_st[1]), req, "state1 unchanged", state1, m_st[1]);
        check(count0 == CW'(m_cnt[0]), req, "count0 unchanged", count0, m_cnt[0]);
        check(count1 == CW'(m_cnt[1]), req, "count1 unchanged", count1, m_cnt[1]);
    endtask

    task automatic set_state(input int slot, input int val);
        @(negedge clk);
        ctl_we = 1'b1; ctl_slot = 1'(slot); ctl_state = 2'(val);
        @(negedge clk);
        ctl_we = 1'b0;
        m_st[slot] = val;
        check(((slot == 0) ? state0 : state1) == 2'(val), "R12", "state after write",
              (slot == 0) ? state0 : state1, val);
    endtask

    // Driver: build the expected image, queue it, then stream the payload.
    task automatic send_frame(input int len, input int seed, input int err_at,
                              input int exp_target, input string req);
        logic [7:0] pay[$];
        logic [7:0] padded[$];
        logic [31:0] f;
        for (int i = 0; i < len; i++) pay.push_back(pay_byte(seed, i));
        if (exp_target >= 0) begin
            padded = pay;
            while (padded.size() < 60) padded.push_back(8'h00);
            f = ref_fcs(padded);
            for (int i = 0; i < 7; i++) exp_img.push_back(8'h55);
            exp_img.push_back(8'hD5);
            foreach (padded[i]) exp_img.push_back(padded[i]);
            for (int k = 0; k < 4; k++) exp_img.push_back(8'(f >> (8 * k)));
            exp_plen.push_back(len);
            exp_slot.push_back(exp_target);
            m_st[exp_target] = 2;
            m_cnt[exp_target] = padded.size() + 12;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pay[i];
            in_last = (i == len - 1); in_err = (i == err_at);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        if (exp_target >= 0) begin
            while (exp_slot.size() != 0 || mon_busy) @(negedge clk);
        end else begin
            repeat (30) @(negedge clk);
            check_slots_kept(req);
        end
    endtask

    // Monitor: wait for each queued frame to complete and compare count, flags and image.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_slot.size() > 0) begin
                int s, plen, n, t, bad_pre, bad_pay, bad_fcs;
                logic [7:0] e, a, fa, fe;
                mon_busy = 1;
                s = exp_slot.pop_front();
                plen = exp_plen.pop_front();
                n = ((plen < 60) ? 60 : plen) + 12;
                t = 0;
                while (((s == 0) ? state0 : state1) != 2'd2 && t < 20000) begin
                    @(negedge clk); t++;
                end
                check(((s == 0) ? state0 : state1) == 2'd2, "R7", "slot pending", (s == 0) ? state0 : state1, 2);
                check(((s == 0) ? count0 : count1) == CW'(n), "R7", "count", (s == 0) ? count0 : count1, n);
                check(rx_irq == 1'b1, "R8", "irq with pending slot", rx_irq, 1);
                bad_pre = 0; bad_pay = 0; bad_fcs = 0; fa = 0; fe = 0;
                for (int i = 0; i < n; i++) begin
                    @(negedge clk); rd_slot = 1'(s); rd_addr = AW'(i);
                    @(negedge clk); a = rd_data;
                    e = exp_img.pop_front();
                    if (a != e) begin
                        if (i < 8) bad_pre++;
                        else if (i < n - 4) bad_pay++;
                        else bad_fcs++;
                        if (bad_pre + bad_pay + bad_fcs == 1) begin fa = a; fe = e; end
                    end
                end
                check(bad_pre == 0, "R4", "preamble bytes", fa, fe);
                check(bad_pay == 0, (plen < 60) ? "R5" : "R4", "payload and padding", fa, fe);
                check(bad_fcs == 0, "R6", "fcs bytes", fa, fe);
                mon_busy = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(state0 == 2'd0, "R1", "reset state0", state0, 0);
        check(state1 == 2'd0, "R1", "reset state1", state1, 0);
        check(count0 == '0 && count1 == '0, "R1", "reset counts", {count1, count0}, 0);
        check(rx_irq == 1'b0, "R1", "reset irq", rx_irq, 0);
        check(slot_avail == 1'b0, "R1", "reset avail", slot_avail, 0);

        set_state(0, 1);
        check(slot_avail == 1'b1, "R9", "avail with slot loaded", slot_avail, 1);
        check(rx_irq == 1'b0, "R8", "no irq while only loaded", rx_irq, 0);
        send_frame(64, 1, -1, 0, "R2");
        set_state(1, 1);
        send_frame(10, 2, -1, 1, "R5");
        check(slot_avail == 1'b0, "R9", "avail with both pending", slot_avail, 0);

        set_state(0, 0);
        check(rx_irq == 1'b1, "R8", "irq with one slot pending", rx_irq, 1);
        set_state(1, 0);
        check(rx_irq == 1'b0, "R8", "irq after clearing", rx_irq, 0);
        send_frame(30, 3, -1, -1, "R3");

        set_state(1, 1);
        set_state(0, 1);
        send_frame(60, 4, -1, 0, "R2");
        send_frame(61, 5, -1, 1, "R2");

        set_state(0, 0);
        set_state(1, 0);
        set_state(0, 1);
        send_frame(40, 6, 20, -1, "R10");
        send_frame(45, 7, 44, -1, "R10");
        send_frame(100, 8, -1, 0, "R10");

        set_state(1, 1);
        send_frame(2037, 9, -1, -1, "R11");
        send_frame(2036, 10, -1, 1, "R11");
        check(count1 == CW'(2048), "R11", "count at max payload", count1, 2048);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule